// File: doc/BRIEF.md
# I2C Byte-Store Slave with Page Programming

This block is an I2C target that sits in front of a 256-byte register store. SCL and SDA are sampled with a fast system clock. The block finds START and STOP conditions on the bus. It decodes the address byte against a fixed device-type nibble and three strap inputs. It drives SDA only by pulling it low, through a pull-enable output, so the pad can be open-drain.

A master stores data in two ways. A single-byte store sends one data byte. A page store sends up to 16 data bytes, which land in a page buffer and wrap inside their 16-byte page. The store is programmed only after STOP, during a timed write cycle. The cycle length is a parameter counted in system clocks. While the cycle runs, the block refuses its own address, so the master can poll for completion.

A master reads data in three ways. A random read is a dummy write of the word address, then a repeated START and a read. A current read continues from the remembered pointer. Either read becomes sequential while the master keeps acknowledging, and the pointer wraps over the whole store. A write-protect input refuses data bytes. The same input aborts a write already in progress, so that nothing is programmed.

Top module: `i2cmem_slave`

## Requirements
- R1: After reset every one of the 256 locations reads FFh and SDA is not pulled low.
- R2: Only an address byte whose upper nibble is 1010b and whose next three bits equal `dev_sel_i` is acknowledged. Bit 0 of that byte selects store (0) or read (1). Any other address byte gets no acknowledge, and the rest of that transfer is ignored.
- R3: In a store transfer, the matching address byte, the word-address byte and each accepted data byte are acknowledged by a low on SDA during the ninth SCL clock. A single-byte store then programs the addressed location.
- R4: SDA driven by the block changes only while SCL is low. Data bits go out most significant bit first.
- R5: In a page store, only the low four address bits advance after each data byte. More than 16 bytes wrap and overwrite earlier bytes of the same page. No other page is touched.
- R6: Programming starts at STOP and lasts `WR_CYCLES` clocks. During that time the address byte is not acknowledged, and polling succeeds once the cycle ends.
- R7: A current read returns the byte at the last accessed address plus one. A sequential read continues through the following addresses while the master acknowledges, and wraps from FFh to 00h.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until STOP.
- R9: While `wp_i` is high, data bytes are not acknowledged and nothing is programmed. No write cycle follows, so the next address byte is acknowledged at once.
- R10: `wp_i` going high during the write cycle ends the cycle at once. None of the collected bytes are programmed.
- R11: A repeated START inside a transaction restarts address decoding, so a random read works as a dummy store of the word address followed by a read.
- R12: Only the page bytes that were received are programmed. The other locations of the page keep their values.
- R13: A START followed directly by STOP, after data bytes were sent, discards the pending store. No write cycle follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| sda_pull_o | output | 1 | High pulls SDA low; low releases it |
| dev_sel_i | input | 3 | Strap value compared with address bits 3..1 |
| wp_i | input | 1 | Write-protect and write-abort input |

## Verification
The bench builds the block with `WR_CYCLES` set to 600. With that value, a write cycle lasts about two address polls. This makes acknowledge polling observable, and it leaves enough time to raise the protect input inside a running cycle. The other parameters keep their defaults: a 16-byte page, an 8-bit address and a two-stage synchroniser. With those defaults, page wrap-around, partial-page commit and sequential wrap from FFh to 00h can all be reached with short transfers.

// File: rtl/i2cmem_pkg.sv
// Shared types for the I2C byte-store slave.
// Assumes: byte-wide data on the bus and in the store.
package i2cmem_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA,
        ST_WAITSTOP
    } bus_state_e;
endpackage

// File: rtl/i2cmem_bus_sync.sv
// Brings SCL, SDA and the protect input into the clock domain and derives
// SCL edges plus START/STOP events from the synchronised levels.
// Assumes: the system clock is many times faster than SCL; STAGES >= 2.
module i2cmem_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic scl_o,
    output logic sda_o,
    output logic wp_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int NCH = 3;
    localparam logic [NCH-1:0] IDLE_LVL = 3'b011;

    logic [NCH-1:0] raw;
    logic [NCH-1:0] synced;
    logic           scl_d;
    logic           sda_d;

    assign raw = {wp_i, sda_i, scl_i};

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            logic [STAGES-1:0] pipe;
            // Shift chain per input; resets to the idle bus level.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= {STAGES{IDLE_LVL[g]}};
                else        pipe <= {pipe[STAGES-2:0], raw[g]};
            end
            assign synced[g] = pipe[STAGES-1];
        end
    endgenerate

    assign scl_o = synced[0];
    assign sda_o = synced[1];
    assign wp_o  = synced[2];

    // One-cycle history of the synchronised bus lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_o;
            sda_d <= sda_o;
        end
    end

    assign scl_rise_o = scl_o & ~scl_d;
    assign scl_fall_o = ~scl_o & scl_d;
    assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2cmem_page_buf.sv
// Collects the data bytes of one page store together with a mask of which
// entries were received. Clear has priority over a same-cycle write.
// Assumes: index is the low address bits of the running page pointer.
module i2cmem_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [PAGE_W-1:0]                 idx_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    input  logic                              clr_i,
    output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] data_o,
    output logic [(1<<PAGE_W)-1:0]            mask_o
);
    localparam int PAGE = 1 << PAGE_W;

    // Entry storage and received-mask update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
            data_o <= '0;
        end else if (clr_i) begin
            mask_o <= '0;
        end else if (we_i) begin
            for (int i = 0; i < PAGE; i++) begin
                if (idx_i == PAGE_W'(i)) begin
                    data_o[i] <= wdata_i;
                    mask_o[i] <= 1'b1;
                end
            end
        end
    end

    // R12: after a clear no stale entry may be committed later.
    a_r12_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mask_o == '0));
endmodule

// File: rtl/i2cmem_array.sv
// Byte store of 2**ADDR_W locations. Reset fills every cell with all ones.
// A commit writes the masked entries of a page buffer into one page.
// Assumes: commit is a single-cycle pulse; read is combinational.
module i2cmem_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]           page_i,
    input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0] pdata_i,
    input  logic [(1<<PAGE_W)-1:0]             pmask_i,
    input  logic [ADDR_W-1:0]                  raddr_i,
    output logic [DATA_W-1:0]                  rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Reset fill and masked page commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (commit_i) begin
            for (int j = 0; j < PAGE; j++) begin
                if (pmask_i[j]) cells[{page_i, PAGE_W'(j)}] <= pdata_i[j];
            end
        end
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/i2cmem_slave.sv
// I2C target in front of a byte store. It decodes the address byte, takes
// the word address and data for single and page stores, serves random,
// current and sequential reads, and runs a timed write cycle after STOP.
// Assumes: the system clock oversamples SCL; the bus is open-drain and
// sda_i is the wired line level.
module i2cmem_slave
    import i2cmem_pkg::*;
#(
    parameter int          WR_CYCLES   = 625000,
    parameter int          ADDR_W      = 8,
    parameter int          PAGE_W      = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  DEV_TYPE    = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] dev_sel_i,
    input  logic       wp_i
);
    localparam int PAGE  = 1 << PAGE_W;
    localparam int HI_W  = ADDR_W - PAGE_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic scl_s, sda_s, wp_s, scl_rise, scl_fall, start_det, stop_det;

    bus_state_e         st;
    bus_state_e         nxt;
    logic [3:0]         bitcnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  tx;
    logic [BYTE_W-1:0]  byte_in;
    logic [ADDR_W-1:0]  ptr;
    logic               ack_pend;
    logic               mack;
    logic               sda_low;
    logic               busy;
    logic [CNT_W-1:0]   cnt;
    logic               have_data;
    logic               abort;
    logic               buf_we;
    logic [PAGE_W-1:0]  buf_idx;
    logic [BYTE_W-1:0]  buf_wd;
    logic               buf_clr;
    logic               commit;
    logic [BYTE_W-1:0]  rd_data;
    logic               dev_match;
    logic [PAGE-1:0][BYTE_W-1:0] pg_data;
    logic [PAGE-1:0]             pg_mask;

    i2cmem_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wp_i),
        .scl_o(scl_s), .sda_o(sda_s), .wp_o(wp_s),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    i2cmem_page_buf #(.PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .we_i(buf_we), .idx_i(buf_idx),
        .wdata_i(buf_wd), .clr_i(buf_clr), .data_o(pg_data), .mask_o(pg_mask)
    );

    i2cmem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .page_i(ptr[ADDR_W-1:PAGE_W]),
        .pdata_i(pg_data), .pmask_i(pg_mask), .raddr_i(ptr), .rdata_o(rd_data)
    );

    assign byte_in    = {shreg[BYTE_W-2:0], sda_s};
    assign dev_match  = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == dev_sel_i) && !busy;
    assign sda_pull_o = sda_low;

    // Bus protocol engine, write-cycle timer and abort handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            nxt       <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            tx        <= '0;
            ptr       <= '0;
            ack_pend  <= 1'b0;
            mack      <= 1'b0;
            sda_low   <= 1'b0;
            busy      <= 1'b0;
            cnt       <= '0;
            have_data <= 1'b0;
            abort     <= 1'b0;
            buf_we    <= 1'b0;
            buf_idx   <= '0;
            buf_wd    <= '0;
            buf_clr   <= 1'b0;
            commit    <= 1'b0;
        end else begin
            buf_we  <= 1'b0;
            buf_clr <= 1'b0;
            commit  <= 1'b0;

            // Timed programming; protect input cancels it.
            if (busy) begin
                if (wp_s) begin
                    busy    <= 1'b0;
                    buf_clr <= 1'b0 | 1'b1;
                end else if (cnt == CNT_W'(WR_CYCLES - 1)) begin
                    busy   <= 1'b0;
                    commit <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            // Protect after the first captured data byte cancels the store.
            if (wp_s && have_data && !busy) abort <= 1'b1;

            if (start_det) begin
                st        <= ST_DEV;
                bitcnt    <= '0;
                sda_low   <= 1'b0;
                have_data <= 1'b0;
                abort     <= 1'b0;
                if (!busy) buf_clr <= 1'b1;
            end else if (stop_det) begin
                st        <= ST_IDLE;
                bitcnt    <= '0;
                sda_low   <= 1'b0;
                have_data <= 1'b0;
                abort     <= 1'b0;
                if (!busy) begin
                    if (have_data && !abort && !wp_s) begin
                        busy <= 1'b1;
                        cnt  <= '0;
                    end else begin
                        buf_clr <= 1'b1;
                    end
                end
            end else if (scl_rise && st != ST_IDLE && st != ST_WAITSTOP) begin
                if (bitcnt == 4'd8) begin
                    bitcnt <= 4'd9;
                    mack   <= ~sda_s;
                end else if (bitcnt < 4'd8) begin
                    bitcnt <= bitcnt + 1'b1;
                    if (st != ST_RDATA) shreg <= byte_in;
                    if (st != ST_RDATA && bitcnt == 4'd7) begin
                        unique case (st)
                            ST_DEV: begin
                                ack_pend <= dev_match;
                                nxt      <= byte_in[0] ? ST_RDATA : ST_WADDR;
                                if (!dev_match) st <= ST_IDLE;
                            end
                            ST_WADDR: begin
                                ptr      <= byte_in;
                                ack_pend <= 1'b1;
                                nxt      <= ST_WDATA;
                            end
                            ST_WDATA: begin
                                if (wp_s) begin
                                    ack_pend <= 1'b0;
                                    nxt      <= ST_WAITSTOP;
                                    abort    <= 1'b1;
                                end else begin
                                    ack_pend  <= 1'b1;
                                    nxt       <= ST_WDATA;
                                    buf_we    <= 1'b1;
                                    buf_idx   <= ptr[PAGE_W-1:0];
                                    buf_wd    <= byte_in;
                                    ptr       <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                                    have_data <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end else if (scl_fall && st != ST_IDLE && st != ST_WAITSTOP) begin
                if (st == ST_RDATA) begin
                    if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                        sda_low <= ~tx[BYTE_W-2];
                        tx      <= {tx[BYTE_W-2:0], 1'b0};
                    end else if (bitcnt == 4'd8) begin
                        sda_low <= 1'b0;
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (mack) begin
                            tx      <= rd_data;
                            sda_low <= ~rd_data[BYTE_W-1];
                            ptr     <= ptr + 1'b1;
                        end else begin
                            sda_low <= 1'b0;
                            st      <= ST_WAITSTOP;
                        end
                    end
                end else if (bitcnt == 4'd8) begin
                    sda_low <= ack_pend;
                end else if (bitcnt == 4'd9) begin
                    bitcnt <= '0;
                    st     <= nxt;
                    if (nxt == ST_RDATA) begin
                        tx      <= rd_data;
                        sda_low <= ~rd_data[BYTE_W-1];
                        ptr     <= ptr + 1'b1;
                    end else begin
                        sda_low <= 1'b0;
                    end
                end
            end
        end
    end

    // R1: SDA released in the first cycle out of reset.
    a_r1_released_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_pull_o);

    // R4: the pull-down only changes while synchronised SCL is low.
    a_r4_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s);

    // R6: no acknowledge of an address byte during the write cycle.
    a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st == ST_DEV) |-> !sda_pull_o);

    // R8: nothing driven while waiting for STOP.
    a_r8_waitstop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAITSTOP) |-> !sda_pull_o);

    // R2: an unaddressed or idle slave never drives the bus.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_pull_o);

    // R10: a commit only follows a write cycle that ran to its end.
    a_r10_commit_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(busy) && !busy));
endmodule

// File: tb/i2cmem_slave_test.sv
module i2cmem_slave_test;
    localparam int Q = 8;
    localparam logic [7:0] DEVW = 8'hAA;
    localparam logic [7:0] DEVR = 8'hAB;
    localparam logic [15:0] VEC [0:5] = '{16'h123C, 16'h37A5, 16'h6A00,
                                          16'h9B5A, 16'hC481, 16'hD97E};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, scl, sda_m, wp, sda_pull;
    logic sda_bus;
    assign sda_bus = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_bad = 0;
    int glitches = 0;
    bit done = 1'b0;

    i2cmem_slave #(.WR_CYCLES(600)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .dev_sel_i(3'b101), .wp_i(wp)
    );

    task automatic tick();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bstart();
        sda_m = 1'b1; tick(); scl = 1'b1; tick(); sda_m = 1'b0; tick(); scl = 1'b0; tick();
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(); scl = 1'b1; tick(); sda_m = 1'b1; tick();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(); scl = 1'b1; tick(); tick(); scl = 1'b0; tick();
    endtask

    task automatic recv_bit(output logic b);
        logic early;
        sda_m = 1'b1; tick(); scl = 1'b1; tick();
        early = sda_bus; b = sda_bus; tick();
        if (sda_bus !== early) glitches++;
        scl = 1'b0; tick();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(x);
        ack = ~x;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            d[i] = x;
        end
        send_bit(~mack);
    endtask

    task automatic addr_poll(input logic [7:0] dev, output int polls);
        logic a;
        polls = 0;
        forever begin
            bstart();
            wr_byte(dev, a);
            if (a || polls > 40) break;
            bstop();
            polls++;
        end
    endtask

    task automatic byte_write(input logic [7:0] ad, input logic [7:0] d);
        logic a; int p;
        addr_poll(DEVW, p);
        wr_byte(ad, a);
        wr_byte(d, a);
        bstop();
    endtask

    task automatic rand_read(input logic [7:0] ad, output logic [7:0] d);
        logic a; int p;
        addr_poll(DEVW, p);
        wr_byte(ad, a);
        bstart();
        wr_byte(DEVR, a);
        rd_byte(1'b0, d);
        bstop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a, b;
        logic [7:0] d;
        int p;
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; wp = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 sda released", sda_pull, 1'b0);
        rand_read(8'h33, d);
        chk("R1 reset fill", d, 8'hFF);

        // R2: wrong strap, wrong type
        bstart(); wr_byte(8'hA8, a); chk("R2 strap mismatch nack", a, 1'b0); bstop();
        bstart(); wr_byte(8'h6A, a); chk("R2 type mismatch nack", a, 1'b0); bstop();
        bstart(); wr_byte(DEVW, a); chk("R2 match ack", a, 1'b1);
        wr_byte(8'h70, a); chk("R3 word address ack", a, 1'b1);
        bstop();

        // R3 / R11: vector table of single-byte stores and random reads
        for (int k = 0; k < 6; k++) begin
            byte_write(VEC[k][15:8], VEC[k][7:0]);
            rand_read(VEC[k][15:8], d);
            chk("R3 R11 store then random read", d, VEC[k][7:0]);
        end

        // R5: 18-byte page store from 5Eh wraps inside page 50h
        addr_poll(DEVW, p);
        wr_byte(8'h5E, a);
        for (int j = 0; j < 18; j++) begin
            wr_byte(8'h40 + 8'(j), a);
            chk("R3 data ack", a, 1'b1);
        end
        bstop();
        addr_poll(DEVW, p);
        chk("R6 polling sees busy", (p > 0), 1'b1);
        wr_byte(8'h50, a);
        bstart(); wr_byte(DEVR, a);
        for (int i = 0; i < 17; i++) begin
            int j;
            rd_byte(i != 16, d);
            j = (i + 2) % 16;
            if (j < 2) j += 16;
            if (i < 16) chk("R5 page wrap", d, 8'h40 + 8'(j));
            else        chk("R5 next page untouched", d, 8'hFF);
        end
        bstop();

        // R7: current read after a random read
        rand_read(8'h50, d);
        chk("R7 random read", d, 8'h42);
        bstart(); wr_byte(DEVR, a); rd_byte(1'b0, d); bstop();
        chk("R7 current read is next address", d, 8'h43);

        // R7: sequential wrap FEh -> 00h
        addr_poll(DEVW, p); wr_byte(8'hFE, a); wr_byte(8'h11, a); wr_byte(8'h22, a); bstop();
        addr_poll(DEVW, p); wr_byte(8'hFE, a);
        bstart(); wr_byte(DEVR, a);
        rd_byte(1'b1, d); chk("R7 seq FE", d, 8'h11);
        rd_byte(1'b1, d); chk("R7 seq FF", d, 8'h22);
        rd_byte(1'b0, d); chk("R7 seq wrap 00", d, 8'hFF);

        // R8: after master NACK the bus stays released until STOP
        recv_bit(b);
        chk("R8 released after nack", b, 1'b1);
        chk("R8 no pull", sda_pull, 1'b0);
        bstop();

        // R9: protect refuses data, no write cycle follows
        wp = 1'b1;
        addr_poll(DEVW, p);
        wr_byte(8'h20, a); chk("R9 address ack under protect", a, 1'b1);
        wr_byte(8'h77, a); chk("R9 data nack under protect", a, 1'b0);
        bstop();
        wp = 1'b0;
        tick();
        bstart(); wr_byte(DEVW, a); chk("R9 not busy after refused store", a, 1'b1);
        wr_byte(8'h20, a); bstart(); wr_byte(DEVR, a); rd_byte(1'b0, d); bstop();
        chk("R9 location unchanged", d, 8'hFF);

        // R10: protect pulse during the write cycle aborts it
        byte_write(8'h21, 8'h55);
        repeat (40) @(posedge clk);
        #1 wp = 1'b1;
        repeat (8) @(posedge clk);
        #1 wp = 1'b0;
        bstart(); wr_byte(DEVW, a); chk("R10 free after abort", a, 1'b1);
        wr_byte(8'h21, a); bstart(); wr_byte(DEVR, a); rd_byte(1'b0, d); bstop();
        chk("R10 nothing programmed", d, 8'hFF);

        // R12: partial page commit keeps other bytes
        addr_poll(DEVW, p); wr_byte(8'h80, a);
        for (int i = 0; i < 16; i++) wr_byte(8'hA0 + 8'(i), a);
        bstop();
        addr_poll(DEVW, p); wr_byte(8'h85, a);
        for (int i = 1; i < 4; i++) wr_byte(8'(i), a);
        bstop();
        addr_poll(DEVW, p); wr_byte(8'h80, a);
        bstart(); wr_byte(DEVR, a);
        for (int i = 0; i < 16; i++) begin
            rd_byte(i != 15, d);
            if (i >= 5 && i <= 7) chk("R12 received bytes", d, 8'(i - 4));
            else                  chk("R12 other bytes kept", d, 8'hA0 + 8'(i));
        end
        bstop();

        // R13: START then STOP discards the pending store
        addr_poll(DEVW, p); wr_byte(8'h40, a); wr_byte(8'h99, a);
        bstart(); bstop();
        tick();
        bstart(); wr_byte(DEVW, a); chk("R13 no write cycle", a, 1'b1);
        wr_byte(8'h40, a); bstart(); wr_byte(DEVR, a); rd_byte(1'b0, d); bstop();
        chk("R13 location unchanged", d, 8'hFF);

        // R4: slave data never moved while SCL was high
        chk("R4 stable during SCL high", glitches, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule